// File: doc/BRIEF.md
# Radix-4 Complex Butterfly Unit

This block is the arithmetic core of one radix-4 decimation step. It accepts four complex samples and four complex twiddle factors in a single beat. Each sample is first rotated by its own twiddle factor, all four lanes included. The four rotated values are then merged into four complex results. The merge uses only adders, subtractors and real/imaginary swaps that stand in for multiplication by plus or minus j.

Every real and imaginary part, on input and on output, is a 9-bit two's-complement value. Twiddle parts are read as Q1.7, so 127 stands for almost exactly 1.0. Each partial product is truncated to its integer part. Each combined sum is divided by four and clamped to the 9-bit range, so a large input saturates instead of wrapping. The results are captured in an output register whenever a valid beat arrives. A delayed valid flag marks them. Twiddle storage, stage control and data reordering belong to the surrounding FFT engine.

Top module: `r4_butterfly`

## Requirements
- R1: For lane k (lane 0 = A, 1 = B, 2 = C, 3 = D), the weighted value is p = (xr*wr >>> 7) - (xi*wi >>> 7) + j((xr*wi >>> 7) + (xi*wr >>> 7)). Each 18-bit product is floor-shifted on its own. With all data inputs zero, every result is zero.
- R2: Result lane 0 is sat((p0 + p1 + p2 + p3) >>> 2), applied to the real and imaginary parts separately. Here >>> is an arithmetic (floor) shift and sat clamps to the 9-bit signed range.
- R3: Result lane 1 is sat((p0 - j*p1 - p2 + j*p3) >>> 2). The real part uses p0.re + p1.im - p2.re - p3.im. The imaginary part uses p0.im - p1.re - p2.im + p3.re.
- R4: Result lane 2 is sat((p0 - p1 + p2 - p3) >>> 2) on each part.
- R5: Result lane 3 is sat((p0 + j*p1 - p2 - j*p3) >>> 2). The real part uses p0.re - p1.im - p2.re + p3.im. The imaginary part uses p0.im + p1.re - p2.im - p3.re.
- R6: A shifted sum above 255 gives 255, and one below -256 gives -256. Results never wrap.
- R7: A beat with in_valid high at a rising edge updates the results at that edge. out_valid is in_valid delayed by one clock.
- R8: At an edge where in_valid is low, the results keep their previous values whatever the data and twiddle inputs are. out_valid is low after that edge.
- R9: While rst_n is low (asynchronous, active low), out_valid and every result part are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks a beat whose operands are to be processed |
| x_re | input | 4x9 | Data real parts; element k is lane k (A..D) |
| x_im | input | 4x9 | Data imaginary parts; element k is lane k |
| w_re | input | 4x9 | Twiddle real parts, Q1.7; element k pairs with data lane k |
| w_im | input | 4x9 | Twiddle imaginary parts, Q1.7 |
| out_valid | output | 1 | Results hold a freshly processed beat |
| y_re | output | 4x9 | Result real parts; element k is result lane k |
| y_im | output | 4x9 | Result imaginary parts; element k is result lane k |

## Verification
The results and out_valid for a beat are due one clock after the rising edge that captures it. The bench drives operands on the falling edge and reads the results on the next falling edge, just after the capturing edge. For hold behaviour, the bench drives an idle beat with fresh operands and reads one falling edge later. The outputs must then still equal the previous beat's expected values. Reset checks are taken while rst_n is low, both before the first beat and after results have become nonzero.

// File: rtl/r4bf_pkg.sv
package r4bf_pkg;

    localparam int unsigned NUM_LANES = 4;

    typedef enum logic [1:0] {
        LANE_A = 2'd0,
        LANE_B = 2'd1,
        LANE_C = 2'd2,
        LANE_D = 2'd3
    } lane_e;

endpackage

// File: rtl/r4bf_cmul.sv
module r4bf_cmul #(
    parameter int DW      = 9,
    parameter int TW_FRAC = 7,
    parameter int WW      = 2*DW - TW_FRAC + 1
) (
    input  logic signed [DW-1:0] xr,
    input  logic signed [DW-1:0] xi,
    input  logic signed [DW-1:0] wr,
    input  logic signed [DW-1:0] wi,
    output logic signed [WW-1:0] pr,
    output logic signed [WW-1:0] pi
);

    localparam int PW = 2*DW;
    localparam int SW = PW - TW_FRAC;

    logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;
    logic signed [SW-1:0] s_rr, s_ii, s_ri, s_ir;

    always_comb begin
        m_rr = xr * wr;
        m_ii = xi * wi;
        m_ri = xr * wi;
        m_ir = xi * wr;
        // dropping the low fraction bits is a floor shift of each product
        s_rr = m_rr[PW-1:TW_FRAC];
        s_ii = m_ii[PW-1:TW_FRAC];
        s_ri = m_ri[PW-1:TW_FRAC];
        s_ir = m_ir[PW-1:TW_FRAC];
        pr   = WW'(s_rr) - WW'(s_ii);
        pi   = WW'(s_ri) + WW'(s_ir);
    end

endmodule

// File: rtl/r4bf_combine.sv
module r4bf_combine #(
    parameter int DW        = 9,
    parameter int WW        = 12,
    parameter int OUT_SHIFT = 2
) (
    input  logic [3:0][WW-1:0] p_re,
    input  logic [3:0][WW-1:0] p_im,
    output logic [3:0][DW-1:0] q_re,
    output logic [3:0][DW-1:0] q_im
);

    import r4bf_pkg::*;

    localparam int SUMW = WW + 2;
    localparam logic signed [SUMW-1:0] MAXV = SUMW'(2**(DW-1) - 1);
    localparam logic signed [SUMW-1:0] MINV = -MAXV - SUMW'(1);

    logic signed [SUMW-1:0] ar [NUM_LANES];
    logic signed [SUMW-1:0] ai [NUM_LANES];
    logic signed [SUMW-1:0] sr [NUM_LANES];
    logic signed [SUMW-1:0] si [NUM_LANES];
    logic signed [SUMW-1:0] hr [NUM_LANES];
    logic signed [SUMW-1:0] hi [NUM_LANES];

    always_comb begin
        for (int k = 0; k < NUM_LANES; k++) begin
            ar[k] = SUMW'($signed(p_re[k]));
            ai[k] = SUMW'($signed(p_im[k]));
        end

        // plain sum
        sr[LANE_A] = ar[LANE_A] + ar[LANE_B] + ar[LANE_C] + ar[LANE_D];
        si[LANE_A] = ai[LANE_A] + ai[LANE_B] + ai[LANE_C] + ai[LANE_D];
        // -j on B is (im,-re); +j on D is (-im,re)
        sr[LANE_B] = ar[LANE_A] + ai[LANE_B] - ar[LANE_C] - ai[LANE_D];
        si[LANE_B] = ai[LANE_A] - ar[LANE_B] - ai[LANE_C] + ar[LANE_D];
        // alternating signs
        sr[LANE_C] = ar[LANE_A] - ar[LANE_B] + ar[LANE_C] - ar[LANE_D];
        si[LANE_C] = ai[LANE_A] - ai[LANE_B] + ai[LANE_C] - ai[LANE_D];
        // +j on B, -j on D
        sr[LANE_D] = ar[LANE_A] - ai[LANE_B] - ar[LANE_C] + ai[LANE_D];
        si[LANE_D] = ai[LANE_A] + ar[LANE_B] - ai[LANE_C] - ar[LANE_D];

        for (int k = 0; k < NUM_LANES; k++) begin
            hr[k] = sr[k] >>> OUT_SHIFT;
            hi[k] = si[k] >>> OUT_SHIFT;
            if (hr[k] > MAXV)      q_re[k] = MAXV[DW-1:0];
            else if (hr[k] < MINV) q_re[k] = MINV[DW-1:0];
            else                   q_re[k] = hr[k][DW-1:0];
            if (hi[k] > MAXV)      q_im[k] = MAXV[DW-1:0];
            else if (hi[k] < MINV) q_im[k] = MINV[DW-1:0];
            else                   q_im[k] = hi[k][DW-1:0];
        end
    end

endmodule

// File: rtl/r4_butterfly.sv
module r4_butterfly #(
    parameter int DW        = 9,
    parameter int TW_FRAC   = 7,
    parameter int OUT_SHIFT = 2,
    parameter bit OUT_REG   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [3:0][DW-1:0] x_re,
    input  logic [3:0][DW-1:0] x_im,
    input  logic [3:0][DW-1:0] w_re,
    input  logic [3:0][DW-1:0] w_im,
    output logic               out_valid,
    output logic [3:0][DW-1:0] y_re,
    output logic [3:0][DW-1:0] y_im
);

    import r4bf_pkg::*;

    localparam int WW = 2*DW - TW_FRAC + 1;

    logic [3:0][WW-1:0] p_re, p_im;
    logic [3:0][DW-1:0] q_re, q_im;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        logic signed [WW-1:0] lane_pr, lane_pi;

        r4bf_cmul #(
            .DW      (DW),
            .TW_FRAC (TW_FRAC),
            .WW      (WW)
        ) i_cmul (
            .xr (x_re[k]),
            .xi (x_im[k]),
            .wr (w_re[k]),
            .wi (w_im[k]),
            .pr (lane_pr),
            .pi (lane_pi)
        );

        assign p_re[k] = lane_pr;
        assign p_im[k] = lane_pi;
    end

    r4bf_combine #(
        .DW        (DW),
        .WW        (WW),
        .OUT_SHIFT (OUT_SHIFT)
    ) i_combine (
        .p_re (p_re),
        .p_im (p_im),
        .q_re (q_re),
        .q_im (q_im)
    );

    if (OUT_REG) begin : g_reg
        typedef struct packed {
            logic               vld;
            logic [3:0][DW-1:0] yr;
            logic [3:0][DW-1:0] yi;
        } out_st_t;

        out_st_t st_d, st_q;

        always_comb begin
            st_d     = st_q;
            st_d.vld = in_valid;
            if (in_valid) begin
                st_d.yr = q_re;
                st_d.yi = q_im;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign out_valid = st_q.vld;
        assign y_re      = st_q.yr;
        assign y_im      = st_q.yi;
    end else begin : g_comb
        assign out_valid = in_valid;
        assign y_re      = q_re;
        assign y_im      = q_im;
    end

endmodule

// File: rtl/r4bf_checker.sv
module r4bf_checker #(
    parameter int DW      = 9,
    parameter bit OUT_REG = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [3:0][DW-1:0] x_re,
    input logic [3:0][DW-1:0] x_im,
    input logic               out_valid,
    input logic [3:0][DW-1:0] y_re,
    input logic [3:0][DW-1:0] y_im
);

    if (OUT_REG) begin : g_chk
        assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

        assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);

        assert_hold_results_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(y_re) && $stable(y_im)));

        assert_zero_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && x_re == '0 && x_im == '0) |=> (y_re == '0 && y_im == '0));

        assert_reset_clear_R9: assert property (@(posedge clk)
            !rst_n |=> (!out_valid && y_re == '0 && y_im == '0));
    end

endmodule

bind r4_butterfly r4bf_checker #(
    .DW      (DW),
    .OUT_REG (OUT_REG)
) i_r4bf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .x_re      (x_re),
    .x_im      (x_im),
    .out_valid (out_valid),
    .y_re      (y_re),
    .y_im      (y_im)
);

// File: tb/test_r4_butterfly.sv
module test_r4_butterfly;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 9;
    localparam int WDOG       = 200000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [3:0][DW-1:0] x_re = '0, x_im = '0, w_re = '0, w_im = '0;
    logic               out_valid;
    logic [3:0][DW-1:0] y_re, y_im;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int xr [4], xi [4], wr [4], wi [4];
    int e_re [4], e_im [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    r4_butterfly i_r4_butterfly (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .x_re      (x_re),
        .x_im      (x_im),
        .w_re      (w_re),
        .w_im      (w_im),
        .out_valid (out_valid),
        .y_re      (y_re),
        .y_im      (y_im)
    );

    function automatic int sat9(int v);
        if (v > 255)  return 255;
        if (v < -256) return -256;
        return v;
    endfunction

    task automatic model();
        int pr [4];
        int pi [4];
        int sr [4];
        int si [4];
        for (int k = 0; k < 4; k++) begin
            pr[k] = ((xr[k]*wr[k]) >>> 7) - ((xi[k]*wi[k]) >>> 7);
            pi[k] = ((xr[k]*wi[k]) >>> 7) + ((xi[k]*wr[k]) >>> 7);
        end
        sr[0] = pr[0] + pr[1] + pr[2] + pr[3];
        si[0] = pi[0] + pi[1] + pi[2] + pi[3];
        sr[1] = pr[0] + pi[1] - pr[2] - pi[3];
        si[1] = pi[0] - pr[1] - pi[2] + pr[3];
        sr[2] = pr[0] - pr[1] + pr[2] - pr[3];
        si[2] = pi[0] - pi[1] + pi[2] - pi[3];
        sr[3] = pr[0] - pi[1] - pr[2] + pi[3];
        si[3] = pi[0] + pr[1] - pi[2] - pr[3];
        for (int k = 0; k < 4; k++) begin
            e_re[k] = sat9(sr[k] >>> 2);
            e_im[k] = sat9(si[k] >>> 2);
        end
    endtask

    task automatic drive_ops(bit vld);
        for (int k = 0; k < 4; k++) begin
            x_re[k] = DW'(xr[k]);
            x_im[k] = DW'(xi[k]);
            w_re[k] = DW'(wr[k]);
            w_im[k] = DW'(wi[k]);
        end
        in_valid = vld;
    endtask

    task automatic check_int(string req, string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    function automatic string lane_req(int k);
        case (k)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // compare all eight result parts with e_re/e_im; tag "" means per-lane tag
    task automatic check_results(string tag);
        for (int k = 0; k < 4; k++) begin
            string req;
            int    g_re, g_im;
            req  = (tag == "") ? lane_req(k) : tag;
            g_re = $signed(y_re[k]);
            g_im = $signed(y_im[k]);
            check_int(req, $sformatf("lane%0d re", k), g_re, e_re[k]);
            check_int(req, $sformatf("lane%0d im", k), g_im, e_im[k]);
        end
    endtask

    // drive at falling edge, result captured at next rising edge, read at next falling edge
    task automatic run_beat(string tag);
        @(negedge clk);
        model();
        drive_ops(1'b1);
        @(negedge clk);
        check_int("R7", "out_valid after beat", int'(out_valid), 1);
        check_results(tag);
    endtask

    task automatic clear_ops();
        for (int k = 0; k < 4; k++) begin
            xr[k] = 0; xi[k] = 0; wr[k] = 0; wi[k] = 0;
        end
    endtask

    function automatic int rnd9();
        return int'($urandom_range(511)) - 256;
    endfunction

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        clear_ops();
        // reset state, R9
        repeat (3) @(negedge clk);
        check_int("R9", "out_valid in reset", int'(out_valid), 0);
        for (int k = 0; k < 4; k++) begin
            e_re[k] = 0; e_im[k] = 0;
        end
        check_results("R9");
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R9", "out_valid after release", int'(out_valid), 0);

        // zero data gives zero results, R1
        clear_ops();
        for (int k = 0; k < 4; k++) begin
            wr[k] = 127; wi[k] = -90;
        end
        run_beat("R1");

        // single-lane sweep exposes each weighted value, R1
        for (int lane = 0; lane < 4; lane++) begin
            for (int xv = -256; xv <= 255; xv += 31) begin
                for (int wv = -256; wv <= 255; wv += 29) begin
                    clear_ops();
                    xr[lane] = xv;
                    xi[lane] = ((xv*5 + 77 + 2560) % 512) - 256;
                    wr[lane] = wv;
                    wi[lane] = ((wv*3 + 11 + 1536) % 512) - 256;
                    run_beat("R1");
                end
            end
        end

        // unit twiddles on all lanes with distinct data, R2..R5
        clear_ops();
        for (int k = 0; k < 4; k++) begin
            xr[k] = 40*k - 70; xi[k] = 100 - 33*k; wr[k] = 127; wi[k] = 0;
        end
        run_beat("");
        for (int k = 0; k < 4; k++) begin
            wr[k] = 0; wi[k] = 127;
        end
        run_beat("");

        // random all-lane beats, R2..R5
        for (int n = 0; n < 3000; n++) begin
            for (int k = 0; k < 4; k++) begin
                xr[k] = rnd9(); xi[k] = rnd9(); wr[k] = rnd9(); wi[k] = rnd9();
            end
            run_beat("");
        end

        // positive clamp: each weighted real part is 1022, R6
        for (int k = 0; k < 4; k++) begin
            xr[k] = -256; xi[k] = -256; wr[k] = -256; wi[k] = 255;
        end
        model();
        check_int("R6", "model positive clamp", e_re[0], 255);
        run_beat("R6");
        // negative clamp: each weighted real part is -1022, R6
        for (int k = 0; k < 4; k++) begin
            xr[k] = -256; xi[k] = -256; wr[k] = 255; wi[k] = -256;
        end
        model();
        check_int("R6", "model negative clamp", e_re[0], -256);
        run_beat("R6");
        // clamp on lanes 1 and 3 through the j swaps, R6
        clear_ops();
        xr[1] = -256; xi[1] = -256; wr[1] = 255; wi[1] = -256;
        xr[3] = -256; xi[3] = -256; wr[3] = -256; wi[3] = 255;
        run_beat("R6");

        // idle beats with new operands: results held, out_valid low, R8
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            for (int k = 0; k < 4; k++) begin
                xr[k] = rnd9(); xi[k] = rnd9(); wr[k] = rnd9(); wi[k] = rnd9();
            end
            drive_ops(1'b0);
            @(negedge clk);
            check_int("R8", "out_valid idle", int'(out_valid), 0);
            check_results("R8");
        end

        // valid back-to-back then a single idle, R7
        for (int k = 0; k < 4; k++) begin
            xr[k] = 9*k + 3; xi[k] = -5*k; wr[k] = 100; wi[k] = 50;
        end
        run_beat("");
        for (int k = 0; k < 4; k++) xr[k] = -xr[k];
        run_beat("R7");
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check_int("R7", "out_valid one cycle after drop", int'(out_valid), 0);

        // reset after nonzero results clears everything, R9
        check_int("R9", "results nonzero before reset", int'(y_re != '0 || y_im != '0), 1);
        rst_n = 1'b0;
        #1;
        check_int("R9", "out_valid asynchronous reset", int'(out_valid), 0);
        for (int k = 0; k < 4; k++) begin
            e_re[k] = 0; e_im[k] = 0;
        end
        check_results("R9");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule